// File: doc/BRIEF.md
# Measurement Alert Limit Monitor

This block watches the results coming out of a current/voltage measurement path. It takes a signed shunt-voltage result with a completion strobe, an unsigned bus-voltage result with its own completion strobe, and a computed power value. It checks one selected quantity against a single shared limit, keeps an alert flag and a conversion-ready flag, and drives an open-drain alert line. The line is modelled as a pull-low enable.

Two registers are reached through a small register port. Address 0 is the mask/enable register, which holds the function enables, the polarity and the latch mode, and reports the two flags. Address 1 is the alert-limit register. The surrounding logic also sends a strobe whenever the configuration register is written. That strobe, like a read of the mask/enable register, clears the flags.

Top module: `alert_limit_monitor`

## Requirements
- R1: After reset both registers read 0 and `alert_pull_low` is 0. The mask/enable register (address 0) holds writable bits 15:10 (function and conversion-ready enables), bit 1 (polarity) and bit 0 (latch enable). It reads the alert flag at bit 4 and the conversion-ready flag at bit 3, and every other bit reads 0. The limit register (address 1) stores all 16 bits. A write to the mask/enable register leaves both flags unchanged.
- R2: Function enables are bit 15 shunt-over, bit 14 shunt-under, bit 13 bus-over, bit 12 bus-under and bit 11 power-over. When several are set, only the highest set bit is evaluated.
- R3: Shunt functions are evaluated only on `shunt_done`, with signed two's-complement compares. Over trips when the value is greater than the limit, and under trips when it is less. Equal values never trip.
- R4: Bus and power functions are evaluated only on `bus_done`, with unsigned compares and the same strict greater/less rule.
- R5: With the latch enable clear, each evaluation sets the alert flag to that compare's result, so a passing compare clears it.
- R6: With the latch enable set, a tripped alert flag stays set across passing compares until a mask/enable read or a configuration-write strobe.
- R7: The conversion-ready flag sets on every `bus_done` and clears on a mask/enable read or a configuration-write strobe. A `bus_done` in the same cycle wins.
- R8: The alert is asserted when the alert flag is set, or when the conversion-ready flag and its enable (bit 10) are both set. With polarity 0, `alert_pull_low` equals the asserted state. With polarity 1, it is its inverse.
- R9: A mask/enable read returns the flags as they stood before the read, then clears the alert flag in either latch mode. An evaluation in the same cycle takes precedence over the clear.
- R10: With no function enable set, completion strobes leave the alert flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shunt_val | input | 16 | Shunt-voltage result, two's complement |
| shunt_done | input | 1 | One-cycle strobe: shunt result valid |
| bus_val | input | 16 | Bus-voltage result, unsigned |
| bus_done | input | 1 | One-cycle strobe: bus result valid, end of conversion cycle |
| power_val | input | 16 | Computed power, unsigned, valid with `bus_done` |
| reg_addr | input | 1 | 0 = mask/enable register, 1 = limit register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cfg_wr | input | 1 | Strobe: configuration register written |
| alert_pull_low | output | 1 | 1 = pull the open-drain alert line low |

## Verification
The shunt functions are driven with negative values and a negative limit. These tell a signed compare from an unsigned one. The bus functions are driven with values above 0x8000, which tell an unsigned compare from a signed one. Values equal to the limit separate strict from inclusive compares. Strobes of the conversion type that does not own the selected function show that each compare is tied to its own conversion. With all enables set, or three set, the stimulus makes only the lower-priority functions trip, which exposes a wrong priority order. The alert-flag sequences are repeated with latching on and off, and with reads and configuration strobes in between, including a read that coincides with an evaluation.

// File: rtl/alert_limit_monitor.sv
module alert_limit_monitor #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] shunt_val,
  input  logic         shunt_done,
  input  logic [W-1:0] bus_val,
  input  logic         bus_done,
  input  logic [W-1:0] power_val,
  input  logic         reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cfg_wr,
  output logic         alert_pull_low
);
  localparam int NEN = 6;
  localparam int EN_LO = W - NEN;

  typedef enum logic [2:0] {F_NONE, F_SOV, F_SUN, F_BOV, F_BUN, F_POV} fsel_t;

  logic [NEN-1:0] en_q;
  logic           pol_q, latch_q;
  logic [W-1:0]   limit_q;
  logic           flag_q, ready_q;
  fsel_t          fsel;
  logic           trip, eval, clr, mask_wr;

  // en_q[5]=shunt over ... en_q[1]=power over, en_q[0]=ready enable
  always_comb begin
    fsel = F_NONE;
    if      (en_q[5]) fsel = F_SOV;
    else if (en_q[4]) fsel = F_SUN;
    else if (en_q[3]) fsel = F_BOV;
    else if (en_q[2]) fsel = F_BUN;
    else if (en_q[1]) fsel = F_POV;
  end

  always_comb begin
    trip = 1'b0;
    eval = 1'b0;
    unique case (fsel)
      F_SOV: begin eval = shunt_done; trip = $signed(shunt_val) > $signed(limit_q); end
      F_SUN: begin eval = shunt_done; trip = $signed(shunt_val) < $signed(limit_q); end
      F_BOV: begin eval = bus_done;   trip = bus_val > limit_q; end
      F_BUN: begin eval = bus_done;   trip = bus_val < limit_q; end
      F_POV: begin eval = bus_done;   trip = power_val > limit_q; end
      default: ;
    endcase
  end

  assign clr     = (reg_rd && !reg_addr) || cfg_wr;
  assign mask_wr = reg_wr && !reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= 1'b0;
      latch_q <= 1'b0;
      limit_q <= '0;
    end else if (reg_wr) begin
      if (mask_wr) begin
        en_q    <= reg_wdata[W-1:EN_LO];
        pol_q   <= reg_wdata[1];
        latch_q <= reg_wdata[0];
      end else begin
        limit_q <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (eval)     flag_q <= latch_q ? ((flag_q && !clr) || trip) : trip;
      else if (clr) flag_q <= 1'b0;
      if (bus_done) ready_q <= 1'b1;
      else if (clr) ready_q <= 1'b0;
    end
  end

  assign reg_rdata = reg_addr ? limit_q
                   : {en_q, {(EN_LO-5){1'b0}}, flag_q, ready_q, 1'b0, pol_q, latch_q};

  assign alert_pull_low = (flag_q || (en_q[0] && ready_q)) ^ pol_q;

  AST_READY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> ready_q); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !eval) |=> !flag_q); // R9
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && flag_q && !clr && !reg_wr) |=> flag_q); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shunt_done && !bus_done && !clr) |=> $stable(flag_q)); // R10
  AST_ACTIVE_LOW_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !pol_q) |-> alert_pull_low); // R8
  AST_ACTIVE_HIGH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && pol_q) |-> !alert_pull_low); // R8
endmodule

// File: tb/sim_alert_limit_monitor.sv
module sim_alert_limit_monitor;
  logic clk = 0, rst_n = 0;
  logic [15:0] shunt_val = 0, bus_val = 0, power_val = 0, reg_wdata = 0;
  logic shunt_done = 0, bus_done = 0, reg_addr = 0, reg_wr = 0, reg_rd = 0, cfg_wr = 0;
  logic [15:0] reg_rdata;
  logic alert_pull_low;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alert_limit_monitor u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic shunt(input logic [15:0] v);
    @(negedge clk); shunt_val = v; shunt_done = 1;
    @(negedge clk); shunt_done = 0;
  endtask

  task automatic bus(input logic [15:0] v, input logic [15:0] p);
    @(negedge clk); bus_val = v; power_val = p; bus_done = 1;
    @(negedge clk); bus_done = 0;
  endtask

  task automatic cfg();
    @(negedge clk); cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_eq("R1 reset pull", {15'b0, alert_pull_low}, 16'h0);
    rd(0, d); chk_eq("R1 reset mask", d, 16'h0);
    rd(1, d); chk_eq("R1 reset limit", d, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(0, 16'hFFFF); rd(0, d); chk_eq("R1 mask readback", d, 16'hFC03);
    wr(1, 16'h1234); rd(1, d); chk_eq("R1 limit readback", d, 16'h1234);
    wr(0, 16'h0000); cfg();
  endtask

  task automatic t_shunt();
    wr(0, 16'h8000); wr(1, 16'hFFF0);
    shunt(16'hFFEC); chk_eq("R3 sov -20>-16 no", {15'b0, alert_pull_low}, 16'h0);
    shunt(16'h0005); chk_eq("R3 sov 5>-16 trip", {15'b0, alert_pull_low}, 16'h1);
    bus(16'h0000, 16'h0000); chk_eq("R3 bus strobe ignored", {15'b0, alert_pull_low}, 16'h1);
    shunt(16'hFFF0); chk_eq("R3 R5 equal passes", {15'b0, alert_pull_low}, 16'h0);
    wr(0, 16'h4000); wr(1, 16'h0000);
    shunt(16'hFFFF); chk_eq("R3 sun -1<0 signed", {15'b0, alert_pull_low}, 16'h1);
    shunt(16'h0000); cfg();
  endtask

  task automatic t_bus();
    wr(0, 16'h2000); wr(1, 16'h8000);
    bus(16'h9000, 0); chk_eq("R4 bov unsigned", {15'b0, alert_pull_low}, 16'h1);
    shunt(16'h7FFF); chk_eq("R4 shunt strobe ignored", {15'b0, alert_pull_low}, 16'h1);
    bus(16'h8000, 0); chk_eq("R4 bov equal", {15'b0, alert_pull_low}, 16'h0);
    wr(0, 16'h1000); wr(1, 16'h0010);
    bus(16'h000F, 0); chk_eq("R4 bun trip", {15'b0, alert_pull_low}, 16'h1);
    wr(0, 16'h0800); wr(1, 16'd100);
    bus(0, 16'd101); chk_eq("R4 pov trip", {15'b0, alert_pull_low}, 16'h1);
    bus(0, 16'd100); chk_eq("R4 pov equal", {15'b0, alert_pull_low}, 16'h0);
    cfg();
  endtask

  task automatic t_priority();
    wr(0, 16'hF800); wr(1, 16'd10);
    shunt(16'd5); chk_eq("R2 sov wins over sun", {15'b0, alert_pull_low}, 16'h0);
    bus(16'd20, 16'd200); chk_eq("R2 bus funcs ignored", {15'b0, alert_pull_low}, 16'h0);
    shunt(16'd11); chk_eq("R2 sov trips", {15'b0, alert_pull_low}, 16'h1);
    wr(0, 16'h3800);
    bus(16'd5, 16'd50); chk_eq("R2 bov wins", {15'b0, alert_pull_low}, 16'h0);
    cfg();
  endtask

  task automatic t_latch();
    logic [15:0] d;
    wr(0, 16'h8001); wr(1, 16'h0000);
    shunt(16'd3); chk_eq("R6 latch set", {15'b0, alert_pull_low}, 16'h1);
    shunt(16'hFFFF); chk_eq("R6 latch holds", {15'b0, alert_pull_low}, 16'h1);
    cfg(); chk_eq("R6 cfg clears", {15'b0, alert_pull_low}, 16'h0);
    shunt(16'd3); rd(0, d);
    chk_eq("R9 read shows flag", d & 16'h0010, 16'h0010);
    chk_eq("R6 R9 read clears", {15'b0, alert_pull_low}, 16'h0);
    @(negedge clk); reg_addr = 0; reg_rd = 1; shunt_val = 16'd3; shunt_done = 1;
    @(negedge clk); reg_rd = 0; shunt_done = 0;
    chk_eq("R9 eval wins over read", {15'b0, alert_pull_low}, 16'h1);
    cfg();
  endtask

  task automatic t_transparent();
    wr(0, 16'h8000); wr(1, 16'h0000);
    shunt(16'd3); chk_eq("R5 flag set", {15'b0, alert_pull_low}, 16'h1);
    wr(0, 16'h0000); chk_eq("R1 mask write keeps flag", {15'b0, alert_pull_low}, 16'h1);
    shunt(16'hFFFF); bus(0, 0); chk_eq("R10 no function unchanged", {15'b0, alert_pull_low}, 16'h1);
    wr(0, 16'h8000);
    begin logic [15:0] d; rd(0, d); end
    chk_eq("R9 transparent read clears", {15'b0, alert_pull_low}, 16'h0);
  endtask

  task automatic t_ready();
    logic [15:0] d;
    wr(0, 16'h0400);
    bus(0, 0); chk_eq("R8 ready on alert", {15'b0, alert_pull_low}, 16'h1);
    rd(0, d); chk_eq("R7 ready flag read", d & 16'h0008, 16'h0008);
    chk_eq("R7 read clears ready", {15'b0, alert_pull_low}, 16'h0);
    wr(0, 16'h0000);
    bus(0, 0); chk_eq("R8 ready masked", {15'b0, alert_pull_low}, 16'h0);
    rd(0, d); chk_eq("R7 ready set while masked", d & 16'h0008, 16'h0008);
    bus(0, 0); cfg(); rd(0, d); chk_eq("R7 cfg clears ready", d & 16'h0008, 16'h0000);
    @(negedge clk); cfg_wr = 1; bus_done = 1;
    @(negedge clk); cfg_wr = 0; bus_done = 0;
    rd(0, d); chk_eq("R7 set wins over clear", d & 16'h0008, 16'h0008);
  endtask

  task automatic t_polarity();
    wr(0, 16'h0002); chk_eq("R8 high polarity idle", {15'b0, alert_pull_low}, 16'h1);
    wr(0, 16'h8002); wr(1, 16'h0000);
    shunt(16'd3); chk_eq("R8 high polarity active", {15'b0, alert_pull_low}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_shunt();
    t_bus();
    t_priority();
    t_latch();
    t_transparent();
    t_ready();
    t_polarity();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule